// File: doc/BRIEF.md
# Redundant-Copy Commit Result Checker

This block checks the work of two or three redundant copies of the same program. Each copy hands over a record for every selected instruction it commits: a 32-bit result value with its 32-bit address. The copies are not kept in step cycle by cycle. The leading copy may run many instructions ahead, and its records wait in a queue. When the trailing copy commits a record, that record is compared with the oldest waiting leading record. A record matches only when both the address and the value are equal.

An optional third copy has its own queue. In three-copy mode a comparison happens only when all three records for the same commit slot are present. A two-against-one split names the odd copy as the faulty one. A three-way split is reported as unrecoverable.

Any mismatch raises a rollback request. The request flushes every queue and stalls all copies. It stays up until the restart handshake tells the block that all copies have been returned to their last checkpoint. Comparison then starts again from empty queues.

Top module: `redundant_commit_checker`

## Requirements
- R1: After reset, `commit_ok`, `mismatch`, `unrecoverable` and `rollback_req` are 0 and `fault_copy` is 3. `lead_ready` is 1, and `trail_ready` and `third_ready` are 0.
- R2: The leading queue holds DEPTH (16) records. `lead_ready` is 0 exactly while DEPTH records are waiting.
- R3: A trailing record is accepted (`trail_ready` = 1) only while a leading record is waiting, and in three-copy mode only while a third-copy record is also waiting. Records are paired in commit order, oldest first.
- R4: A comparison whose records are all equal in both address and value pulses `commit_ok` for one cycle, starting at the clock edge that accepts the trailing record. `mismatch` is 0 in that cycle.
- R5: In two-copy mode (`tmr_mode` = 0), a difference in address, in value or in both pulses `mismatch` and `unrecoverable` at the edge that accepts the trailing record, with `fault_copy` = 3.
- R6: In three-copy mode, when exactly two copies agree, `mismatch` pulses with `unrecoverable` = 0. `fault_copy` names the odd copy: 0 for the leading copy, 1 for the trailing copy, 2 for the third copy.
- R7: In three-copy mode, when all three records differ, `mismatch` and `unrecoverable` pulse with `fault_copy` = 3.
- R8: `rollback_req` rises in the same cycle as `mismatch`. It stays high until `restart_ack` is sampled 1 at a clock edge, and is 0 from that edge on. `restart_ack` has no effect while `rollback_req` is 0.
- R9: While `rollback_req` is 1, all three ready outputs are 0. After the restart, every queue is empty: records accepted before the error are discarded.
- R10: The leading copy may run up to DEPTH records ahead of the trailing copy, with every record still compared correctly.
- R11: In two-copy mode, `third_ready` is 0 and the third-copy inputs have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_mode | input | 1 | 1 selects three-copy voting. Change it only while the queues are empty |
| lead_valid | input | 1 | Leading copy offers a record |
| lead_ready | output | 1 | Leading queue can take a record |
| lead_addr | input | 32 | Leading record address |
| lead_data | input | 32 | Leading record value |
| trail_valid | input | 1 | Trailing copy offers a record |
| trail_ready | output | 1 | A comparison can be made this cycle |
| trail_addr | input | 32 | Trailing record address |
| trail_data | input | 32 | Trailing record value |
| third_valid | input | 1 | Third copy offers a record |
| third_ready | output | 1 | Third-copy queue can take a record |
| third_addr | input | 32 | Third-copy record address |
| third_data | input | 32 | Third-copy record value |
| restart_ack | input | 1 | All copies have been restored to the checkpoint |
| commit_ok | output | 1 | One-cycle pulse: records agreed |
| mismatch | output | 1 | One-cycle pulse: records disagreed |
| fault_copy | output | 2 | Faulty copy with `mismatch` (0 leading, 1 trailing, 2 third). Reads 3 when no copy can be named |
| unrecoverable | output | 1 | One-cycle pulse: the faulty copy cannot be named |
| rollback_req | output | 1 | Checkpoint rollback request, held until restart |

## Verification
All result flags are registered. Each one appears right after the rising edge that accepts the trailing record and lasts until the next edge. The bench therefore raises valid at a falling edge, waits for the accepting rising edge and samples 1 ns later. Ready outputs come only from registered queue counts and the control state, so they are read at the falling edge, before anything is driven. A restart takes effect at the edge where `restart_ack` is sampled, and `rollback_req` and the ready outputs are read just after that edge.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  typedef enum logic [1:0] {
    FID_LEAD  = 2'd0,
    FID_TRAIL = 2'd1,
    FID_THIRD = 2'd2,
    FID_NONE  = 2'd3
  } fault_id_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } ctrl_state_e;

endpackage

// File: rtl/rcc_fifo.sv
module rcc_fifo #(
  parameter int unsigned WIDTH = 64,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             wr_en;

  assign wr_en = push & ~flush;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q] <= wdata;
  end

  assign rdata = mem[rd_q];
  assign full  = (cnt_q == CAP);
  assign empty = (cnt_q == '0);

  // R2: the queue never takes a record beyond its capacity
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R3: a comparison never consumes a record that is not there
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/rcc_voter.sv
module rcc_voter
  import rcc_pkg::*;
#(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] rec_lead,
  input  logic [WIDTH-1:0] rec_trail,
  input  logic [WIDTH-1:0] rec_third,
  input  logic             tmr,
  output logic             mis,
  output logic             unrec,
  output fault_id_e        fid
);
  logic eq_lt, eq_lh, eq_th;

  assign eq_lt = (rec_lead  == rec_trail);
  assign eq_lh = (rec_lead  == rec_third);
  assign eq_th = (rec_trail == rec_third);

  always_comb begin
    mis   = 1'b0;
    unrec = 1'b0;
    fid   = FID_NONE;
    if (!tmr) begin
      mis   = ~eq_lt;
      unrec = ~eq_lt;
    end else if (eq_lt && eq_lh) begin
      mis = 1'b0;
    end else if (eq_lt) begin
      mis = 1'b1;
      fid = FID_THIRD;
    end else if (eq_lh) begin
      mis = 1'b1;
      fid = FID_TRAIL;
    end else if (eq_th) begin
      mis = 1'b1;
      fid = FID_LEAD;
    end else begin
      mis   = 1'b1;
      unrec = 1'b1;
    end
  end

endmodule

// File: rtl/rcc_ctrl.sv
module rcc_ctrl
  import rcc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fire,
  input  logic      mis,
  input  logic      unrec,
  input  fault_id_e fid,
  input  logic      restart_ack,
  output logic      run,
  output logic      commit_ok,
  output logic      mismatch,
  output logic      unrecoverable,
  output fault_id_e fault_copy,
  output logic      rollback_req
);
  ctrl_state_e state_q, state_d;
  logic        commit_q, commit_d;
  logic        mism_q, mism_d;
  logic        unrec_q, unrec_d;
  fault_id_e   fid_q, fid_d;
  logic        act;

  assign run = (state_q == ST_RUN);
  assign act = fire & run;

  always_comb begin
    state_d  = state_q;
    commit_d = act & ~mis;
    mism_d   = act & mis;
    unrec_d  = act & mis & unrec;
    fid_d    = (act & mis) ? fid : FID_NONE;
    case (state_q)
      ST_RUN:  if (act && mis)  state_d = ST_HOLD;
      ST_HOLD: if (restart_ack) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      commit_q <= 1'b0;
      mism_q   <= 1'b0;
      unrec_q  <= 1'b0;
      fid_q    <= FID_NONE;
    end else begin
      state_q  <= state_d;
      commit_q <= commit_d;
      mism_q   <= mism_d;
      unrec_q  <= unrec_d;
      fid_q    <= fid_d;
    end
  end

  assign commit_ok     = commit_q;
  assign mismatch      = mism_q;
  assign unrecoverable = unrec_q;
  assign fault_copy    = fid_q;
  assign rollback_req  = (state_q == ST_HOLD);

  // R8: the request is held until the restart handshake arrives
  assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rollback_req && !restart_ack) |=> rollback_req);
  // R8: the restart handshake releases the request at the next edge
  assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rollback_req && restart_ack) |=> !rollback_req);

endmodule

// File: rtl/redundant_commit_checker.sv
module redundant_commit_checker
  import rcc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned DEPTH    = 16,
  parameter bit          THIRD_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_mode,
  input  logic              lead_valid,
  output logic              lead_ready,
  input  logic [ADDR_W-1:0] lead_addr,
  input  logic [DATA_W-1:0] lead_data,
  input  logic              trail_valid,
  output logic              trail_ready,
  input  logic [ADDR_W-1:0] trail_addr,
  input  logic [DATA_W-1:0] trail_data,
  input  logic              third_valid,
  output logic              third_ready,
  input  logic [ADDR_W-1:0] third_addr,
  input  logic [DATA_W-1:0] third_data,
  input  logic              restart_ack,
  output logic              commit_ok,
  output logic              mismatch,
  output logic [1:0]        fault_copy,
  output logic              unrecoverable,
  output logic              rollback_req
);
  localparam int unsigned REC_W = ADDR_W + DATA_W;

  logic             run, tmr, fire, flush;
  logic             lead_full, lead_empty, third_full, third_empty;
  logic [REC_W-1:0] lead_head, third_head, trail_rec;
  logic             v_mis, v_unrec;
  fault_id_e        v_fid, fid_out;

  assign tmr       = tmr_mode & THIRD_EN;
  assign trail_rec = {trail_addr, trail_data};

  assign lead_ready  = run & ~lead_full;
  assign trail_ready = run & ~lead_empty & (~tmr | ~third_empty);
  assign fire        = trail_valid & trail_ready;
  assign flush       = ~run | (fire & v_mis);

  rcc_fifo #(.WIDTH(REC_W), .DEPTH(DEPTH)) u_lead_q (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (lead_valid & lead_ready),
    .wdata ({lead_addr, lead_data}),
    .pop   (fire),
    .rdata (lead_head),
    .full  (lead_full),
    .empty (lead_empty)
  );

  generate
    if (THIRD_EN) begin : g_third
      assign third_ready = run & tmr & ~third_full;
      rcc_fifo #(.WIDTH(REC_W), .DEPTH(DEPTH)) u_third_q (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (third_valid & third_ready),
        .wdata ({third_addr, third_data}),
        .pop   (fire & tmr),
        .rdata (third_head),
        .full  (third_full),
        .empty (third_empty)
      );
    end else begin : g_no_third
      assign third_ready = 1'b0;
      assign third_full  = 1'b1;
      assign third_empty = 1'b1;
      assign third_head  = '0;
    end
  endgenerate

  rcc_voter #(.WIDTH(REC_W)) u_voter (
    .rec_lead  (lead_head),
    .rec_trail (trail_rec),
    .rec_third (third_head),
    .tmr       (tmr),
    .mis       (v_mis),
    .unrec     (v_unrec),
    .fid       (v_fid)
  );

  rcc_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire          (fire),
    .mis           (v_mis),
    .unrec         (v_unrec),
    .fid           (v_fid),
    .restart_ack   (restart_ack),
    .run           (run),
    .commit_ok     (commit_ok),
    .mismatch      (mismatch),
    .unrecoverable (unrecoverable),
    .fault_copy    (fid_out),
    .rollback_req  (rollback_req)
  );

  assign fault_copy = fid_out;

  // R9: every copy is stalled while the rollback is pending
  assert_hold_stalls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rollback_req |-> (!lead_ready && !trail_ready && !third_ready));
  // R8: a mismatch always comes with the rollback request
  assert_flag_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> rollback_req);
  // R4: a comparison yields one outcome only
  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_ok && mismatch));
  // R6: a recoverable mismatch always names a copy
  assert_named_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && !unrecoverable) |-> (fault_copy != 2'd3));
  // R11: the third copy is never accepted in two-copy mode
  assert_third_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_mode |-> !third_ready);
  // R3: no comparison without a waiting leading record
  assert_trail_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trail_ready |-> !lead_empty);

endmodule

// File: tb/redundant_commit_checker_bench.sv
module redundant_commit_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tmr_mode = 1'b0;
  logic        lead_valid = 1'b0, trail_valid = 1'b0, third_valid = 1'b0;
  logic [31:0] lead_addr = '0, lead_data = '0;
  logic [31:0] trail_addr = '0, trail_data = '0;
  logic [31:0] third_addr = '0, third_data = '0;
  logic        restart_ack = 1'b0;
  logic        lead_ready, trail_ready, third_ready;
  logic        commit_ok, mismatch, unrecoverable, rollback_req;
  logic [1:0]  fault_copy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  redundant_commit_checker u_redundant_commit_checker (
    .clk(clk), .rst_n(rst_n), .tmr_mode(tmr_mode),
    .lead_valid(lead_valid), .lead_ready(lead_ready),
    .lead_addr(lead_addr), .lead_data(lead_data),
    .trail_valid(trail_valid), .trail_ready(trail_ready),
    .trail_addr(trail_addr), .trail_data(trail_data),
    .third_valid(third_valid), .third_ready(third_ready),
    .third_addr(third_addr), .third_data(third_data),
    .restart_ack(restart_ack),
    .commit_ok(commit_ok), .mismatch(mismatch), .fault_copy(fault_copy),
    .unrecoverable(unrecoverable), .rollback_req(rollback_req)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put_lead(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    lead_addr = a; lead_data = d; lead_valid = 1'b1;
    @(posedge clk); #1;
    lead_valid = 1'b0;
  endtask

  task automatic put_third(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    third_addr = a; third_data = d; third_valid = 1'b1;
    @(posedge clk); #1;
    third_valid = 1'b0;
  endtask

  // drives a trailing record; results are read right after the accepting edge
  task automatic put_trail(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    chk("R3", "trail_ready before compare", 32'(trail_ready), 32'd1);
    trail_addr = a; trail_data = d; trail_valid = 1'b1;
    @(posedge clk); #1;
    trail_valid = 1'b0;
  endtask

  task automatic expect_result(input string req, input bit ok, input bit unr,
                               input logic [1:0] fid);
    chk(req, "commit_ok", 32'(commit_ok), 32'(ok));
    chk(req, "mismatch", 32'(mismatch), 32'(!ok));
    chk(req, "unrecoverable", 32'(unrecoverable), 32'(unr));
    chk(req, "fault_copy", 32'(fault_copy), 32'(fid));
    chk("R8", "rollback_req with result", 32'(rollback_req), 32'(!ok));
  endtask

  task automatic do_restart();
    @(negedge clk);
    chk("R9", "lead_ready in hold", 32'(lead_ready), 32'd0);
    chk("R9", "trail_ready in hold", 32'(trail_ready), 32'd0);
    chk("R9", "third_ready in hold", 32'(third_ready), 32'd0);
    repeat (3) @(negedge clk);
    chk("R8", "rollback_req held", 32'(rollback_req), 32'd1);
    restart_ack = 1'b1;
    @(posedge clk); #1;
    restart_ack = 1'b0;
    chk("R8", "rollback_req released", 32'(rollback_req), 32'd0);
    chk("R9", "lead queue free after restart", 32'(lead_ready), 32'd1);
    chk("R9", "nothing left to compare", 32'(trail_ready), 32'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: reset state
    chk("R1", "commit_ok", 32'(commit_ok), 32'd0);
    chk("R1", "mismatch", 32'(mismatch), 32'd0);
    chk("R1", "unrecoverable", 32'(unrecoverable), 32'd0);
    chk("R1", "rollback_req", 32'(rollback_req), 32'd0);
    chk("R1", "fault_copy", 32'(fault_copy), 32'd3);
    chk("R1", "lead_ready", 32'(lead_ready), 32'd1);
    chk("R1", "trail_ready", 32'(trail_ready), 32'd0);
    chk("R1", "third_ready", 32'(third_ready), 32'd0);

    // R10 / R2 / R4: drift sweep, leading copy k records ahead
    for (int k = 1; k <= 16; k++) begin
      for (int i = 0; i < k; i++)
        put_lead(32'(k * 256 + i), 32'(k * 7919 + i * 31));
      @(negedge clk);
      chk("R2", "lead_ready at fill level", 32'(lead_ready), 32'(k < 16));
      for (int i = 0; i < k; i++) begin
        put_trail(32'(k * 256 + i), 32'(k * 7919 + i * 31));
        expect_result("R10", 1'b1, 1'b0, 2'd3);
      end
      @(negedge clk);
      chk("R3", "trail_ready once drained", 32'(trail_ready), 32'd0);
    end

    // R8: restart_ack while running changes nothing
    put_lead(32'h55, 32'h66);
    @(negedge clk); restart_ack = 1'b1;
    @(posedge clk); #1; restart_ack = 1'b0;
    chk("R8", "ack ignored, no request", 32'(rollback_req), 32'd0);
    put_trail(32'h55, 32'h66);
    expect_result("R8", 1'b1, 1'b0, 2'd3);

    // R5 / R9: two-copy mismatches in address, value, or both
    for (int m = 1; m <= 3; m++) begin
      for (int i = 0; i < 3; i++) put_lead(32'(16'hA000 + i), 32'(16'hB000 + i));
      put_trail(32'hA000 ^ ((m & 1) != 0 ? 32'h10 : 32'h0),
                32'hB000 ^ ((m & 2) != 0 ? 32'h1 : 32'h0));
      expect_result("R5", 1'b0, 1'b1, 2'd3);
      do_restart();
    end
    // R9: stale records gone - a fresh pair compares cleanly
    put_lead(32'h77, 32'h88);
    put_trail(32'h77, 32'h88);
    expect_result("R9", 1'b1, 1'b0, 2'd3);

    // three-copy sweep over every combination of record variants
    @(negedge clk); tmr_mode = 1'b1;
    @(negedge clk);
    chk("R11", "third_ready in three-copy mode", 32'(third_ready), 32'd1);
    for (int va = 0; va < 3; va++)
      for (int vb = 0; vb < 3; vb++)
        for (int vc = 0; vc < 3; vc++) begin
          logic [1:0] fid;
          bit ok, unr;
          put_lead(32'h100 + (va == 2 ? 32'h40 : 32'h0), 32'hA0 + 32'(va == 1));
          @(negedge clk);
          chk("R3", "trail waits for third copy", 32'(trail_ready), 32'd0);
          put_third(32'h100 + (vc == 2 ? 32'h40 : 32'h0), 32'hA0 + 32'(vc == 1));
          put_trail(32'h100 + (vb == 2 ? 32'h40 : 32'h0), 32'hA0 + 32'(vb == 1));
          ok = (va == vb) && (vb == vc);
          unr = (va != vb) && (vb != vc) && (va != vc);
          if (ok || unr) fid = 2'd3;
          else if (va == vb) fid = 2'd2;
          else if (va == vc) fid = 2'd1;
          else fid = 2'd0;
          expect_result(ok ? "R4" : (unr ? "R7" : "R6"), ok, unr, fid);
          if (!ok) do_restart();
        end

    // R11: third-copy inputs ignored in two-copy mode
    @(negedge clk); tmr_mode = 1'b0;
    @(negedge clk);
    chk("R11", "third_ready in two-copy mode", 32'(third_ready), 32'd0);
    third_valid = 1'b1; third_addr = 32'hDEAD; third_data = 32'hBEEF;
    put_lead(32'h321, 32'h654);
    put_trail(32'h321, 32'h654);
    expect_result("R11", 1'b1, 1'b0, 2'd3);
    third_valid = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule